// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device is still holding after a reset cut a transaction short. It acts only through two open-drain pull-down enables, one for SCL and one for SDA. It watches both wires through a two-stage synchronizer. After one start pulse it runs a fixed recovery order. First comes a settle interval with both wires released. Next is a pseudo-stop, sent only when both wires read high. If that attempt is blocked, one extra clock pulse follows with a second conditional pseudo-stop. Nine clock pulses come next, driven whatever SCL does. A last conditional pseudo-stop ends the run. Each low or high phase lasts one half-period, set in system clock cycles by a parameter.

A pseudo-stop pulls SDA low for one half-period and then releases it for one half-period. A target that sees this takes it as an abort of any pending write. The nine clock pulses drain a read the target was partway through, and one of them serves as the not-acknowledge. At the end both wires are released, and a one-cycle done pulse tells the caller the bus may be handed back to the normal controller.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, and whenever no sequence is running, both pull enables are 0 (released) and done is 0.
- R2: A start pulse seen while idle begins a released settle half-period in the next cycle. Every later phase lasts exactly HALF_CYCLES cycles, and the phases follow one another with no gap.
- R3: A pseudo-stop (SDA pull = 1 for one half-period, then both released for one half-period) is sent only if both synchronized wires read high in the last cycle of the preceding half-period.
- R4: If the pseudo-stop attempt after the settle phase is blocked, the block gives one SCL pulse: SCL pull = 1 for one half-period, then released for one half-period. It then makes the conditional pseudo-stop attempt once more.
- R5: After the first pseudo-stop, or after the retry (sent or not), exactly nine SCL pulses follow, each low then released for one half-period. They are sent even if SCL is held low by another device.
- R6: After the nine pulses, one more conditional pseudo-stop attempt is made (same condition as R3).
- R7: done is 1 for exactly one cycle, the cycle after the last half-period ends, with both pull enables 0.
- R8: A start pulse that arrives while a sequence is running has no effect on the output pattern.
- R9: The block never pulls SCL and SDA at the same time. Output encoding {scl_pull_o, sda_pull_o}: 00 released, 10 clock low, 01 data low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| scl_i | input | 1 | Sampled SCL wire level (asynchronous) |
| sda_i | input | 1 | Sampled SDA wire level (asynchronous) |
| scl_pull_o | output | 1 | 1 enables the SCL open-drain pull-down |
| sda_pull_o | output | 1 | 1 enables the SDA open-drain pull-down |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The assertions take for granted that the wire levels reach the sampling point only through the synchronizer. They also assume that start pulses are single-cycle events, and that HALF_CYCLES is a few times larger than the synchronizer depth, so a wire that is released settles within one half-period. The stimulus models each wire as a wired-AND of the block's pull and a target pull. A target pull changes only on the falling system clock edge. The target releases SDA only after a counted SCL falling edge, which keeps every change well inside a half-period and away from the sampling cycle.

// File: rtl/recov_pkg.sv
// Package: shared types for the bus recovery sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package recov_pkg;

    // Kind of half-period currently on the wires.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_PS_LOW,
        PH_PS_HIGH,
        PH_CLK_LOW,
        PH_CLK_HIGH
    } phase_e;

    // Which part of the fixed recovery order a phase belongs to.
    typedef enum logic [1:0] {
        STEP_ENTRY,
        STEP_RETRY,
        STEP_DRAIN,
        STEP_FINAL
    } step_e;

    // Pull enables {scl, sda} for a phase: only one wire is ever pulled.
    function automatic logic [1:0] line_drive(phase_e ph);
        case (ph)
            PH_PS_LOW:  return 2'b01;
            PH_CLK_LOW: return 2'b10;
            default:    return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/recov_line_sync.sv
// Module: multi-stage synchronizer for the sampled wire levels.
// Assumes: STAGES >= 2; inputs may change at any time; reset value is
// "released" (all ones), matching an idle bus.
module recov_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] lines_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], lines_i};
    end

    assign lines_o = chain_q[STAGES-1];

endmodule

// File: rtl/recov_half_timer.sv
// Module: half-period timer; emits a tick in the last cycle of each
// half-period while run is high.
// Assumes: HALF_CYCLES >= 2; run rises in the first cycle of a sequence.
module recov_half_timer #(
    parameter int HALF_CYCLES = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int TW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    // Count cycles within the current half-period; hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/recov_sequencer.sv
// Module: recovery order state machine. Steps through settle,
// conditional pseudo-stop (with one clock and a retry if blocked),
// the drain pulses and a final conditional pseudo-stop.
// Assumes: tick_i marks the last cycle of each half-period; lines_high_i
// is the synchronized "both wires high" condition.
module recov_sequencer
    import recov_pkg::*;
#(
    parameter int N_DRAIN = 9
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   tick_i,
    input  logic   lines_high_i,
    output phase_e phase_o,
    output logic   done_o
);

    localparam int DW = $clog2(N_DRAIN + 1);
    localparam logic [DW-1:0] LAST_PULSE = DW'(N_DRAIN - 1);

    phase_e         phase_q;
    step_e          step_q;
    logic [DW-1:0]  pulse_q;
    logic           done_q;

    // Advance the phase at each half-period boundary; start only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= STEP_ENTRY;
            pulse_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SETTLE;
                        step_q  <= STEP_ENTRY;
                        pulse_q <= '0;
                    end
                end
                PH_SETTLE: begin
                    if (tick_i) begin
                        if (lines_high_i) begin
                            phase_q <= PH_PS_LOW;
                            step_q  <= STEP_ENTRY;
                        end else begin
                            phase_q <= PH_CLK_LOW;
                            step_q  <= STEP_RETRY;
                        end
                    end
                end
                PH_PS_LOW: begin
                    if (tick_i) phase_q <= PH_PS_HIGH;
                end
                PH_PS_HIGH: begin
                    if (tick_i) begin
                        if (step_q == STEP_FINAL) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_CLK_LOW;
                            step_q  <= STEP_DRAIN;
                            pulse_q <= '0;
                        end
                    end
                end
                PH_CLK_LOW: begin
                    if (tick_i) phase_q <= PH_CLK_HIGH;
                end
                PH_CLK_HIGH: begin
                    if (tick_i) begin
                        if (step_q == STEP_RETRY) begin
                            if (lines_high_i) begin
                                phase_q <= PH_PS_LOW;
                            end else begin
                                phase_q <= PH_CLK_LOW;
                                step_q  <= STEP_DRAIN;
                                pulse_q <= '0;
                            end
                        end else if (pulse_q == LAST_PULSE) begin
                            if (lines_high_i) begin
                                phase_q <= PH_PS_LOW;
                                step_q  <= STEP_FINAL;
                            end else begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end
                        end else begin
                            phase_q <= PH_CLK_LOW;
                            pulse_q <= pulse_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;

endmodule

// File: rtl/i2c_bus_recovery.sv
// Module: top of the bus recovery sequencer. Synchronizes the wire
// levels, times half-periods and drives the open-drain pull enables.
// Assumes: the pull enables feed open-drain pads; scl_i/sda_i are the
// pad levels, asynchronous to clk.
module i2c_bus_recovery
    import recov_pkg::*;
#(
    parameter int HALF_CYCLES = 625,
    parameter int SYNC_STAGES = 2,
    parameter int N_DRAIN     = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic done_o
);

    logic [1:0] lines_sync;
    logic       tick;
    phase_e     phase;

    recov_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({scl_i, sda_i}),
        .lines_o (lines_sync)
    );

    recov_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (phase != PH_IDLE),
        .tick_o (tick)
    );

    recov_sequencer #(.N_DRAIN(N_DRAIN)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tick_i       (tick),
        .lines_high_i (&lines_sync),
        .phase_o      (phase),
        .done_o       (done_o)
    );

    // Decode the registered phase into the pull enables.
    assign {scl_pull_o, sda_pull_o} = line_drive(phase);

endmodule

// File: rtl/i2c_bus_recovery_chk.sv
// Checker: timing and safety properties of the recovery sequencer,
// bound to the top module.
// Assumes: single-cycle start pulses; HALF_CYCLES >= 2.
module i2c_bus_recovery_chk #(
    parameter int HALF_CYCLES = 625
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_pull_o,
    input logic       sda_pull_o,
    input logic       done_o,
    input logic [1:0] lines_sync
);

    localparam int RW = $clog2(HALF_CYCLES + 2) + 1;

    logic [1:0]    drv;
    logic [1:0]    drv_q;
    logic [RW-1:0] run_q;

    assign drv = {scl_pull_o, sda_pull_o};

    // Track how many cycles the pull pattern has been stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= 2'b00;
            run_q <= '0;
        end else begin
            drv_q <= drv;
            if (drv != drv_q) run_q <= RW'(1);
            else if (run_q != RW'(HALF_CYCLES + 1)) run_q <= run_q + 1'b1;
        end
    end

    p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != drv_q && drv_q != 2'b00) |-> (run_q == RW'(HALF_CYCLES)));

    p_ps_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(&lines_sync));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_release_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scl_pull_o && !sda_pull_o));

    p_single_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_pull_o && sda_pull_o));

endmodule

bind i2c_bus_recovery i2c_bus_recovery_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .done_o     (done_o),
    .lines_sync (lines_sync)
);

// File: tb/i2c_bus_recovery_tb.sv
`timescale 1ns/1ps
module i2c_bus_recovery_tb;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_pull, sda_pull, done;
    logic tgt_scl_low = 1'b0;
    logic tgt_sda_low = 1'b0;
    logic scl_line, sda_line;

    int vectors = 0;
    int fails = 0;
    int falls = 0;
    int release_at = 0;
    logic scl_prev = 1'b1;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    event       mon_go;
    bit         mon_busy = 1'b0;

    always #4 clk = ~clk;

    // Wired-AND model of the two open-drain wires.
    assign scl_line = !(scl_pull || tgt_scl_low);
    assign sda_line = !(sda_pull || tgt_sda_low);

    i2c_bus_recovery #(.HALF_CYCLES(HALF)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .scl_i      (scl_line),
        .sda_i      (sda_line),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull),
        .done_o     (done)
    );

    // Target model: counts SCL falling edges and lets go of SDA on a chosen one.
    always @(negedge clk) begin
        if (scl_prev && !scl_line) begin
            falls = falls + 1;
            if (falls == release_at) tgt_sda_low = 1'b0;
        end
        scl_prev = scl_line;
    end

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {scl,sda,done} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [1:0] d, input string t);
        exp_q.push_back(d);
        tag_q.push_back(t);
    endtask

    task automatic push_ps(input string t);
        push(2'b01, t);
        push(2'b00, t);
    endtask

    task automatic push_clk(input string t);
        push(2'b10, t);
        push(2'b00, t);
    endtask

    task automatic push_drain();
        for (int i = 0; i < 9; i++) push_clk("R5 drain pulse");
    endtask

    // Monitor: pops one expected half-period at a time and compares every cycle.
    initial begin
        forever begin
            @(mon_go);
            while (exp_q.size() > 0) begin
                logic [1:0] e;
                string      t;
                logic       ok;
                logic [2:0] bad;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                ok = 1'b1;
                bad = 3'b000;
                for (int c = 0; c < HALF; c++) begin
                    if ({scl_pull, sda_pull, done} !== {e, 1'b0} && ok) begin
                        ok = 1'b0;
                        bad = {scl_pull, sda_pull, done};
                    end
                    @(negedge clk);
                end
                check(t, ok ? {e, 1'b0} : bad, {e, 1'b0});
            end
            check("R7 done pulse, lines released", {scl_pull, sda_pull, done}, 3'b001);
            @(negedge clk);
            check("R7 done lasts one cycle", {scl_pull, sda_pull, done}, 3'b000);
            repeat (3 * HALF) @(negedge clk);
            check("R1 idle after sequence", {scl_pull, sda_pull, done}, 3'b000);
            mon_busy = 1'b0;
        end
    end

    // Driver: set up the target, pulse start, optionally inject a second start.
    task automatic run_seq(input logic hold_scl, input logic hold_sda,
                           input int rel_at, input int inject_after);
        tgt_scl_low = hold_scl;
        tgt_sda_low = hold_sda;
        release_at  = rel_at;
        falls       = 0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mon_busy = 1'b1;
        ->mon_go;
        if (inject_after > 0) begin
            fork
                begin
                    repeat (inject_after) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            join_none
        end
        wait (!mon_busy);
        tgt_scl_low = 1'b0;
        tgt_sda_low = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs during reset", {scl_pull, sda_pull, done}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 outputs after reset", {scl_pull, sda_pull, done}, 3'b000);

        // Idle bus: first pseudo-stop sent, drain, final pseudo-stop sent.
        push(2'b00, "R2 settle phase");
        push_ps("R3 first pseudo-stop");
        push_drain();
        push_ps("R6 final pseudo-stop");
        run_seq(1'b0, 1'b0, 0, 0);

        // SDA stuck low throughout: extra clock, no pseudo-stop at all.
        push(2'b00, "R2 settle phase");
        push_clk("R4 extra clock");
        push_drain();
        run_seq(1'b0, 1'b1, 0, 0);

        // SDA released on the extra clock: retry pseudo-stop is sent.
        push(2'b00, "R2 settle phase");
        push_clk("R4 extra clock");
        push_ps("R4 retry pseudo-stop");
        push_drain();
        push_ps("R6 final pseudo-stop");
        run_seq(1'b0, 1'b1, 1, 0);

        // SDA released midway through the drain: only the final attempt succeeds.
        push(2'b00, "R2 settle phase");
        push_clk("R4 extra clock");
        push_drain();
        push_ps("R6 final pseudo-stop after late release");
        run_seq(1'b0, 1'b1, 6, 0);

        // SCL stuck low: clocks still driven, no pseudo-stop.
        push(2'b00, "R2 settle phase");
        push_clk("R5 extra clock with SCL held");
        for (int i = 0; i < 9; i++) push_clk("R5 unconditional pulse with SCL held");
        run_seq(1'b1, 1'b0, 0, 0);

        // Second start while running is ignored.
        push(2'b00, "R8 settle phase");
        push_ps("R8 first pseudo-stop");
        for (int i = 0; i < 9; i++) push_clk("R8 drain with stray start");
        push_ps("R8 final pseudo-stop");
        run_seq(1'b0, 1'b0, 0, 5 * HALF + 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule